// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of an asynchronous flash bus and turns word read requests into timed bus cycles. A request carries a word address and is taken on a valid/ready handshake. The controller then drives the address and pulls chip enable and output enable low, with write enable held high. It counts down a programmable number of clock cycles and samples the data bus on the cycle after the count runs out. The word comes back with a single-cycle response strobe.

The flash groups four consecutive words into a page. The two lowest address bits select the word, and the remaining bits name the page. Once a page has been read, the controller remembers it as the open page. Later reads that land in the same page use a short wait. The first read of a page, and any read that moves to another page, use the long initial wait.

The controller forgets the open page at reset and whenever it lets chip enable go high. After a response, it keeps chip enable low for a bounded number of idle cycles. If no request arrives in that window, chip enable is released and the next read pays the long wait again.

Top module: `fpr_read_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0, and flash_ce_n, flash_oe_n and flash_we_n are all 1.
- R2: A request is taken only in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance up to, but not including, the response cycle.
- R3: From the cycle after acceptance until the response cycle, flash_ce_n and flash_oe_n are 0, flash_we_n is 1, and flash_addr holds the accepted address without change.
- R4: The first read after reset, or after the open page has been dropped, gives rsp_valid exactly INIT_WAIT+2 cycles after its accept cycle.
- R5: A read whose page matches the open page gives rsp_valid exactly PAGE_WAIT+2 cycles after its accept cycle.
- R6: A read to a page other than the open one uses the INIT_WAIT+2 latency, and it makes that page the open page.
- R7: The page is address bits [AW-1:2] and the word within the page is bits [1:0]. Two addresses that differ only in bits [1:0] share a page.
- R8: Idle cycles are numbered from 0, where cycle 0 is the response cycle. While a page is open, flash_ce_n stays 0 in idle cycles 0 to IDLE_LIMIT-1. If nothing is accepted by then, flash_ce_n is 1 from idle cycle IDLE_LIMIT onward, and the next read uses the long latency.
- R9: rsp_valid is high for exactly one cycle per read. In that cycle rsp_data equals the value the data bus carried one cycle earlier, and req_ready is 1 so that a new request may be accepted in the same cycle.
- R10: flash_we_n is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_addr | input | AW | Word address of the request |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | DW | Read data |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low (always high) |
| flash_addr | output | AW | Flash word address |
| flash_dq_in | input | DW | Flash data bus |

## Verification
Two events can fall in one cycle: the response of one read and the acceptance of the next read. This happens on the response cycle, which is idle cycle 0. The bench provokes it by raising req_valid in the same cycle it first sees rsp_valid. It then checks that the new read is taken at once and still counts as a same-page hit when its page matches.

A second collision sits at the edge of the idle window, where acceptance and the drop of the open page compete. The bench sweeps request gaps across that boundary and judges each case in three ways:
- the latency the bench predicts from its own page model,
- the level of flash_ce_n in each idle cycle,
- the returned data.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_SAMPLE = 2'd2
    } fpr_state_e;
endpackage

// File: rtl/fpr_wait_timer.sv
module fpr_wait_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R4
    load_sets_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/fpr_page_tracker.sv
module fpr_page_tracker #(
    parameter int PW         = 6,
    parameter int IDLE_LIMIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          in_idle,
    input  logic [PW-1:0] page_in,
    output logic          hit,
    output logic          page_open
);
    localparam int ICW = $clog2(IDLE_LIMIT + 1);

    typedef struct packed {
        logic           valid;
        logic [PW-1:0]  page;
        logic [ICW-1:0] icnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (accept) begin
            trk_d.valid = 1'b1;
            trk_d.page  = page_in;
            trk_d.icnt  = '0;
        end else if (in_idle && trk_q.valid) begin
            if (trk_q.icnt == ICW'(IDLE_LIMIT - 1)) begin
                trk_d.valid = 1'b0;
                trk_d.icnt  = '0;
            end else begin
                trk_d.icnt = trk_q.icnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign hit       = trk_q.valid && (trk_q.page == page_in);
    assign page_open = trk_q.valid;

    // R8
    closed_page_counter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_q.valid |-> (trk_q.icnt == '0));

    // R6
    accept_opens_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (trk_q.valid && trk_q.page == $past(page_in)));
endmodule

// File: rtl/fpr_read_ctrl.sv
module fpr_read_ctrl #(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int INIT_WAIT  = 6,
    parameter int PAGE_WAIT  = 2,
    parameter int IDLE_LIMIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic          flash_we_n,
    output logic [AW-1:0] flash_addr,
    input  logic [DW-1:0] flash_dq_in
);
    import fpr_pkg::*;

    localparam int OFS_W = 2;
    localparam int PW    = AW - OFS_W;
    localparam int CW    = $clog2(INIT_WAIT + 1);

    typedef struct packed {
        fpr_state_e    st;
        logic [AW-1:0] addr;
        logic          rsp_v;
        logic [DW-1:0] data;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          accept, hit, page_open, tmr_done, tmr_load;
    logic [CW-1:0] tmr_val;

    assign accept = req_valid && (ctl_q.st == ST_IDLE);

    fpr_page_tracker #(.PW(PW), .IDLE_LIMIT(IDLE_LIMIT)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_idle   (ctl_q.st == ST_IDLE),
        .page_in   (req_addr[AW-1:OFS_W]),
        .hit       (hit),
        .page_open (page_open)
    );

    fpr_wait_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.st   = ST_ACCESS;
                    ctl_d.addr = req_addr;
                    tmr_load   = 1'b1;
                    tmr_val    = hit ? CW'(PAGE_WAIT - 1) : CW'(INIT_WAIT - 1);
                end
            end
            ST_ACCESS: begin
                if (tmr_done) ctl_d.st = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                ctl_d.rsp_v = 1'b1;
                ctl_d.data  = flash_dq_in;
                ctl_d.st    = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, addr: '0, rsp_v: 1'b0, data: '0};
        else        ctl_q <= ctl_d;
    end

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign rsp_valid  = ctl_q.rsp_v;
    assign rsp_data   = ctl_q.data;
    assign flash_ce_n = !((ctl_q.st != ST_IDLE) || page_open);
    assign flash_oe_n = (ctl_q.st == ST_IDLE);
    assign flash_we_n = 1'b1;
    assign flash_addr = ctl_q.addr;

    // Checker state: length of the access phase and the hit decision of the read in flight
    logic [CW:0] acc_len_q;
    logic        hit_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_len_q <= '0;
            hit_q     <= 1'b0;
        end else begin
            if (accept) begin
                acc_len_q <= '0;
                hit_q     <= hit;
            end else if (ctl_q.st == ST_ACCESS) begin
                acc_len_q <= acc_len_q + 1'b1;
            end
        end
    end

    // R5
    wait_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SAMPLE) |->
            (acc_len_q == (hit_q ? (CW+1)'(PAGE_WAIT) : (CW+1)'(INIT_WAIT))));

    // R9
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    rsp_while_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R3
    bus_controls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (!flash_ce_n && !flash_oe_n && flash_we_n));

    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(flash_addr));

    // R10
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_we_n);
endmodule

// File: tb/tb_fpr_read_ctrl.sv
module tb_fpr_read_ctrl;
    localparam int AW         = 8;
    localparam int DW         = 16;
    localparam int INIT_WAIT  = 6;
    localparam int PAGE_WAIT  = 2;
    localparam int IDLE_LIMIT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          flash_ce_n, flash_oe_n, flash_we_n;
    logic [AW-1:0] flash_addr;
    logic [DW-1:0] flash_dq_in;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return DW'(a * 16'h9E37) ^ 16'h1234;
    endfunction

    assign flash_dq_in = (!flash_ce_n && !flash_oe_n) ? mem_word(flash_addr) : '0;

    fpr_read_ctrl #(
        .AW(AW), .DW(DW), .INIT_WAIT(INIT_WAIT),
        .PAGE_WAIT(PAGE_WAIT), .IDLE_LIMIT(IDLE_LIMIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
        .flash_addr(flash_addr), .flash_dq_in(flash_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Bench page model
    bit            open_valid = 1'b0;
    logic [AW-3:0] open_page  = '0;
    bit            hung       = 1'b0;

    // Issue one read; req_valid is raised at the current negedge.
    task automatic do_read(input logic [AW-1:0] a);
        int  t0, lat, exp_lat;
        bit  got;
        exp_lat = (open_valid && open_page == a[AW-1:2]) ? PAGE_WAIT + 2 : INIT_WAIT + 2;
        req_addr  = a;
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R2 ready before accept", req_ready, 1);
        t0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (rsp_valid) begin
                got = 1'b1;
            end else begin
                check(!req_ready, "R2 ready low while busy", req_ready, 0);
                check(!flash_ce_n && !flash_oe_n && flash_we_n,
                      "R3 bus controls", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b001);
                check(flash_addr == a, "R3 address held", flash_addr, a);
                @(negedge clk);
            end
        end
        if (!got) begin
            hung = 1'b1;
            check(1'b0, "R9 response watchdog", 0, 1);
        end else begin
            lat = cyc - t0;
            if (exp_lat == PAGE_WAIT + 2)
                check(lat == exp_lat, "R5 in-page latency", lat, exp_lat);
            else
                check(lat == exp_lat, "R4/R6 initial latency", lat, exp_lat);
            check(rsp_data == mem_word(a), "R9 data", rsp_data, mem_word(a));
            check(req_ready, "R9 ready in response cycle", req_ready, 1);
            check(flash_we_n, "R10 write enable high", flash_we_n, 1);
            open_valid = 1'b1;
            open_page  = a[AW-1:2];
        end
    endtask

    // Wait g idle cycles after the response cycle, checking chip enable.
    task automatic idle_gap(input int g);
        for (int j = 1; j <= g; j++) begin
            @(negedge clk);
            if (rsp_valid) check(1'b0, "R9 extra response pulse", 1, 0);
            if (open_valid && j >= IDLE_LIMIT) open_valid = 1'b0;
            check(flash_ce_n == !open_valid, "R8 chip enable in idle", flash_ce_n, !open_valid);
        end
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "global watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] a, base;
        repeat (3) @(negedge clk);
        // R1
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
        check({flash_ce_n, flash_oe_n, flash_we_n} == 3'b111, "R1 reset bus", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        check({flash_ce_n, flash_oe_n, flash_we_n} == 3'b111, "R1 idle after reset", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);

        // R4 first access, R7 all four offsets of one page back to back
        base = 8'h40;
        for (int o = 0; o < 4; o++) do_read(base | AW'(o));
        // R6 page change, R5 return within window
        do_read(8'h44);
        do_read(8'h47);
        do_read(8'h43);

        // Sweep: gaps across the idle window edge, pages mixed
        for (int i = 0; i < 240 && !hung; i++) begin
            int g;
            g = i % (IDLE_LIMIT + 3);
            idle_gap(g);
            if (i % 3 == 0) a = AW'((i * 37) & 8'hFC) | AW'(i % 4);
            else            a = {open_page, 2'(i * 3)};
            do_read(a);
        end

        // R8 long gap then same page: must be initial latency
        idle_gap(IDLE_LIMIT + 2);
        do_read({open_page, 2'd1});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule